// File: doc/BRIEF.md
# IDE Timing Register Overlay

This block sits between a host's 8-offset IDE command-block I/O window and the taskfile registers of the drive interface. In normal operation every access passes straight through to the taskfile. A fixed three-access key sequence switches the window into configuration mode. In that mode the same offsets reach a small bank of drive-timing registers, and the taskfile is cut off. A relock write returns the window to taskfile mode.

The block holds two timing sets, one for each attached device. Software first picks a target set, then loads its read-cycle timing, write-cycle timing and address-setup requirement into staging registers. A commit write to the control register copies both staged sets into the active sets: set 0 drives device 0 and set 1 drives device 1. A downstream cycle generator sees the active read and write timing of the device named by the current taskfile device bit. It also sees one address-setup value, shared by both devices, which is the larger of the two active requirements.

The window is driven by a state machine with four states:
- `ST_LOCKED`: idle, taskfile mode.
- `ST_ONE_READ`: one key read seen.
- `ST_TWO_READS`: two key reads seen.
- `ST_CONFIG`: unlocked.

Its transitions are:
- **arm**: a 16-bit read at offset 1 moves `ST_LOCKED` to `ST_ONE_READ`, and `ST_ONE_READ` to `ST_TWO_READS`. In `ST_TWO_READS` it keeps the state.
- **open**: a byte write of 0x03 at offset 2 moves `ST_TWO_READS` to `ST_CONFIG`.
- **break**: any other access in `ST_ONE_READ` or `ST_TWO_READS` returns to `ST_LOCKED`.
- **close**: a byte write of 0x83 at offset 2 moves `ST_CONFIG` to `ST_LOCKED`.

Top module: `ide_timing_overlay`

## Requirements
- R1: The window enters configuration mode (`cfg_mode`=1) after this exact sequence: two consecutive 16-bit reads at offset 1, then a byte write of 0x03 at offset 2. `cfg_mode` rises on the clock edge that samples the write.
- R2: In the two partial-sequence states, any other access returns the detector to `ST_LOCKED`. Examples are a byte read at offset 1, an access at another offset, or a write of a different value. A following 0x03 write then leaves the window locked.
- R3: While unlocked, a byte write of 0x83 at offset 2 relocks the window. Any other write at offset 2 leaves it unlocked.
- R4: While locked, `bus_rd`/`bus_wr` are forwarded to `tf_rd`/`tf_wr` and `bus_rdata` equals `tf_rdata`. While unlocked, `tf_rd` and `tf_wr` stay 0 and reads return configuration data.
- R5: The unlocked map is:
  - offset 0: read timing of the target set
  - offset 1: write timing of the target set
  - offset 3: control
  - offset 5: strap
  - offset 6: miscellaneous

  The other offsets read 0x0000, and writes to them have no effect. Configuration reads return the byte in `bus_rdata[7:0]`, with the upper byte 0.
- R6: A write to the miscellaneous register sets the target set from bit 0. It also loads bits 7:4 as that set's address-setup requirement. The register reads back as {setup, 3'b000, target}.
- R7: A control write of 0x85 copies both staged sets into the active sets. Any other control value is only stored (and read back), and the active sets stay unchanged.
- R8: `rd_timing` and `wr_timing` show the active set selected by `dev_sel`. `addr_setup` is the larger of the two active setup requirements.
- R9: The strap register reads bit 0 as the `clk25_strap` input (0 for a 33 MHz bus clock, 1 for 25 MHz), with all other bits 0.
- R10: After reset the window is locked, control and target are 0, and every staged and active set holds timing 0x59 and setup 3.
- R11: Relocking keeps all staged and active values. After a new unlock they read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Window offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 16 | Read data (taskfile or configuration) |
| tf_rd | output | 1 | Read strobe to taskfile |
| tf_wr | output | 1 | Write strobe to taskfile |
| tf_rdata | input | 16 | Taskfile read data |
| dev_sel | input | 1 | Current taskfile device bit |
| clk25_strap | input | 1 | Bus clock strap (1 = 25 MHz) |
| cfg_mode | output | 1 | Window is in configuration mode |
| rd_timing | output | 8 | Active read timing for the selected device |
| wr_timing | output | 8 | Active write timing for the selected device |
| addr_setup | output | 4 | Shared address setup (maximum of both sets) |

## Verification
The following are combinational from the current state and inputs, so they are due in the same cycle as the access:
- `bus_rdata`
- `tf_rd` and `tf_wr`
- the `dev_sel` effect on the timing outputs

The bench samples them 1 ns after driving the access, before the clock edge. The following take effect on the edge that samples the access:
- `cfg_mode`
- staged register contents
- active timing after a commit

The bench checks them one edge later, after the strobe has dropped. A reference model in the bench applies each access to its own state at that same edge, and the expected values come from that model.

// File: rtl/otr_pkg.sv
package otr_pkg;
    typedef enum logic [1:0] {
        ST_LOCKED    = 2'd0,
        ST_ONE_READ  = 2'd1,
        ST_TWO_READS = 2'd2,
        ST_CONFIG    = 2'd3
    } win_state_t;

    localparam logic [2:0] OFS_RDT   = 3'd0;
    localparam logic [2:0] OFS_WRT   = 3'd1;
    localparam logic [2:0] OFS_ARM   = 3'd1;
    localparam logic [2:0] OFS_KEY   = 3'd2;
    localparam logic [2:0] OFS_CTL   = 3'd3;
    localparam logic [2:0] OFS_STRAP = 3'd5;
    localparam logic [2:0] OFS_MISC  = 3'd6;

    localparam logic [7:0] KEY_OPEN   = 8'h03;
    localparam logic [7:0] KEY_CLOSE  = 8'h83;
    localparam logic [7:0] CTL_COMMIT = 8'h85;
endpackage

// File: rtl/otr_unlock_fsm.sv
module otr_unlock_fsm
    import otr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] addr,
    input  logic       rd,
    input  logic       wr,
    input  logic       wide,
    input  logic [7:0] wdata,
    output logic       cfg_mode
);
    win_state_t state, state_nx;

    logic access, arm_rd, open_wr, close_wr;
    assign access   = rd | wr;
    assign arm_rd   = rd && wide && (addr == OFS_ARM);
    assign open_wr  = wr && !wide && (addr == OFS_KEY) && (wdata == KEY_OPEN);
    assign close_wr = wr && !wide && (addr == OFS_KEY) && (wdata == KEY_CLOSE);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_LOCKED;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOCKED: begin
                if (arm_rd) state_nx = ST_ONE_READ;
            end
            ST_ONE_READ: begin
                if (arm_rd)      state_nx = ST_TWO_READS;
                else if (access) state_nx = ST_LOCKED;
            end
            ST_TWO_READS: begin
                if (open_wr)     state_nx = ST_CONFIG;
                else if (arm_rd) state_nx = ST_TWO_READS;
                else if (access) state_nx = ST_LOCKED;
            end
            ST_CONFIG: begin
                if (close_wr) state_nx = ST_LOCKED;
            end
            default: state_nx = ST_LOCKED;
        endcase
    end

    always_comb begin
        cfg_mode = (state == ST_CONFIG);
    end

    AST_UNLOCK_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONFIG && $past(state) != ST_CONFIG) |->
            ($past(state) == ST_TWO_READS && $past(wr) && $past(addr) == OFS_KEY
             && $past(wdata) == KEY_OPEN)); // R1

    AST_BREAK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_ONE_READ && $past(access) && !$past(arm_rd))
            |-> state == ST_LOCKED); // R2

    AST_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode && close_wr) |=> !cfg_mode); // R3
endmodule

// File: rtl/otr_timing_set.sv
module otr_timing_set #(
    parameter int DATA_W = 8,
    parameter int SETUP_W = 4,
    parameter logic [DATA_W-1:0] DFLT_DATA = 8'h59,
    parameter logic [SETUP_W-1:0] DFLT_SETUP = 4'h3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_rd,
    input  logic               load_wr,
    input  logic               load_setup,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [SETUP_W-1:0] setup_in,
    input  logic               commit,
    output logic [DATA_W-1:0]  stg_rd,
    output logic [DATA_W-1:0]  stg_wr,
    output logic [SETUP_W-1:0] stg_setup,
    output logic [DATA_W-1:0]  act_rd,
    output logic [DATA_W-1:0]  act_wr,
    output logic [SETUP_W-1:0] act_setup
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_rd    <= DFLT_DATA;
            stg_wr    <= DFLT_DATA;
            stg_setup <= DFLT_SETUP;
            act_rd    <= DFLT_DATA;
            act_wr    <= DFLT_DATA;
            act_setup <= DFLT_SETUP;
        end else begin
            if (load_rd)    stg_rd    <= wdata;
            if (load_wr)    stg_wr    <= wdata;
            if (load_setup) stg_setup <= setup_in;
            if (commit) begin
                act_rd    <= stg_rd;
                act_wr    <= stg_wr;
                act_setup <= stg_setup;
            end
        end
    end

    AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(act_rd) && $stable(act_wr) && $stable(act_setup))); // R7
endmodule

// File: rtl/otr_timing_bank.sv
module otr_timing_bank #(
    parameter int NSETS = 2,
    parameter int DATA_W = 8,
    parameter int SETUP_W = 4,
    parameter logic [DATA_W-1:0] DFLT_DATA = 8'h59,
    parameter logic [SETUP_W-1:0] DFLT_SETUP = 4'h3,
    localparam int SEL_W = (NSETS > 1) ? $clog2(NSETS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEL_W-1:0]   target,
    input  logic [SEL_W-1:0]   setup_target,
    input  logic               wr_rd_t,
    input  logic               wr_wr_t,
    input  logic               wr_setup,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [SETUP_W-1:0] setup_in,
    input  logic               commit,
    input  logic [SEL_W-1:0]   dev_sel,
    output logic [DATA_W-1:0]  tgt_rd,
    output logic [DATA_W-1:0]  tgt_wr,
    output logic [SETUP_W-1:0] tgt_setup,
    output logic [DATA_W-1:0]  rd_timing,
    output logic [DATA_W-1:0]  wr_timing,
    output logic [SETUP_W-1:0] addr_setup
);
    logic [DATA_W-1:0]  stg_rd [NSETS];
    logic [DATA_W-1:0]  stg_wr [NSETS];
    logic [SETUP_W-1:0] stg_su [NSETS];
    logic [DATA_W-1:0]  act_rd [NSETS];
    logic [DATA_W-1:0]  act_wr [NSETS];
    logic [SETUP_W-1:0] act_su [NSETS];

    for (genvar g = 0; g < NSETS; g++) begin : g_set
        otr_timing_set #(
            .DATA_W(DATA_W), .SETUP_W(SETUP_W),
            .DFLT_DATA(DFLT_DATA), .DFLT_SETUP(DFLT_SETUP)
        ) i_set (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_rd   (wr_rd_t  && (target == SEL_W'(g))),
            .load_wr   (wr_wr_t  && (target == SEL_W'(g))),
            .load_setup(wr_setup && (setup_target == SEL_W'(g))),
            .wdata     (wdata),
            .setup_in  (setup_in),
            .commit    (commit),
            .stg_rd    (stg_rd[g]),
            .stg_wr    (stg_wr[g]),
            .stg_setup (stg_su[g]),
            .act_rd    (act_rd[g]),
            .act_wr    (act_wr[g]),
            .act_setup (act_su[g])
        );

        AST_SETUP_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
            addr_setup >= act_su[g]); // R8
    end

    always_comb begin
        tgt_rd     = stg_rd[target];
        tgt_wr     = stg_wr[target];
        tgt_setup  = stg_su[target];
        rd_timing  = act_rd[dev_sel];
        wr_timing  = act_wr[dev_sel];
        addr_setup = '0;
        for (int k = 0; k < NSETS; k++) begin
            if (act_su[k] > addr_setup) addr_setup = act_su[k];
        end
    end
endmodule

// File: rtl/ide_timing_overlay.sv
module ide_timing_overlay
    import otr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SETUP_W = 4,
    parameter logic [DATA_W-1:0] DFLT_DATA = 8'h59,
    parameter logic [SETUP_W-1:0] DFLT_SETUP = 4'h3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         bus_addr,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic               bus_wide,
    input  logic [7:0]         bus_wdata,
    output logic [15:0]        bus_rdata,
    output logic               tf_rd,
    output logic               tf_wr,
    input  logic [15:0]        tf_rdata,
    input  logic               dev_sel,
    input  logic               clk25_strap,
    output logic               cfg_mode,
    output logic [DATA_W-1:0]  rd_timing,
    output logic [DATA_W-1:0]  wr_timing,
    output logic [SETUP_W-1:0] addr_setup
);
    localparam int SETUP_LSB = 8 - SETUP_W;

    logic       cfg_wr;
    logic       target;
    logic [7:0] ctl_q;
    logic [DATA_W-1:0]  tgt_rd, tgt_wr;
    logic [SETUP_W-1:0] tgt_setup;

    otr_unlock_fsm i_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .rd      (bus_rd),
        .wr      (bus_wr),
        .wide    (bus_wide),
        .wdata   (bus_wdata),
        .cfg_mode(cfg_mode)
    );

    assign cfg_wr = bus_wr && cfg_mode;
    assign tf_rd  = bus_rd && !cfg_mode;
    assign tf_wr  = bus_wr && !cfg_mode;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target <= 1'b0;
            ctl_q  <= 8'h00;
        end else begin
            if (cfg_wr && bus_addr == OFS_MISC) target <= bus_wdata[0];
            if (cfg_wr && bus_addr == OFS_CTL)  ctl_q  <= bus_wdata;
        end
    end

    otr_timing_bank #(
        .NSETS(2), .DATA_W(DATA_W), .SETUP_W(SETUP_W),
        .DFLT_DATA(DFLT_DATA), .DFLT_SETUP(DFLT_SETUP)
    ) i_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .target      (target),
        .setup_target(bus_wdata[0]),
        .wr_rd_t     (cfg_wr && bus_addr == OFS_RDT),
        .wr_wr_t     (cfg_wr && bus_addr == OFS_WRT),
        .wr_setup    (cfg_wr && bus_addr == OFS_MISC),
        .wdata       (bus_wdata[DATA_W-1:0]),
        .setup_in    (bus_wdata[7:SETUP_LSB]),
        .commit      (cfg_wr && bus_addr == OFS_CTL && bus_wdata == CTL_COMMIT),
        .dev_sel     (dev_sel),
        .tgt_rd      (tgt_rd),
        .tgt_wr      (tgt_wr),
        .tgt_setup   (tgt_setup),
        .rd_timing   (rd_timing),
        .wr_timing   (wr_timing),
        .addr_setup  (addr_setup)
    );

    always_comb begin
        bus_rdata = 16'h0000;
        if (!cfg_mode) begin
            bus_rdata = tf_rdata;
        end else begin
            case (bus_addr)
                OFS_RDT:   bus_rdata[DATA_W-1:0] = tgt_rd;
                OFS_WRT:   bus_rdata[DATA_W-1:0] = tgt_wr;
                OFS_CTL:   bus_rdata[7:0] = ctl_q;
                OFS_STRAP: bus_rdata[0] = clk25_strap;
                OFS_MISC:  bus_rdata[7:0] = {tgt_setup, {(SETUP_LSB-1){1'b0}}, target};
                default:   bus_rdata = 16'h0000;
            endcase
        end
    end

    AST_TF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_mode) && cfg_mode |-> !tf_rd && !tf_wr); // R4
endmodule

// File: tb/test_ide_timing_overlay.sv
module test_ide_timing_overlay;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_wide = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        tf_rd, tf_wr;
    logic [15:0] tf_rdata = 16'hA5C3;
    logic        dev_sel = 1'b0;
    logic        clk25_strap = 1'b0;
    logic        cfg_mode;
    logic [7:0]  rd_timing, wr_timing;
    logic [3:0]  addr_setup;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model
    logic [7:0] m_srd [2];
    logic [7:0] m_swr [2];
    logic [3:0] m_ssu [2];
    logic [7:0] m_ard [2];
    logic [7:0] m_awr [2];
    logic [3:0] m_asu [2];
    logic       m_tgt;
    logic [7:0] m_ctl;
    logic       m_cfg;

    logic [15:0] q;
    logic        trd, twr;

    always #5 clk = ~clk;

    ide_timing_overlay i_ide_timing_overlay (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wide(bus_wide), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tf_rd(tf_rd), .tf_wr(tf_wr), .tf_rdata(tf_rdata), .dev_sel(dev_sel),
        .clk25_strap(clk25_strap), .cfg_mode(cfg_mode), .rd_timing(rd_timing),
        .wr_timing(wr_timing), .addr_setup(addr_setup)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [2:0] a);
        if (!m_cfg) return tf_rdata;
        case (a)
            3'd0: return {8'h00, m_srd[m_tgt]};
            3'd1: return {8'h00, m_swr[m_tgt]};
            3'd3: return {8'h00, m_ctl};
            3'd5: return {15'h0, clk25_strap};
            3'd6: return {8'h00, m_ssu[m_tgt], 3'b000, m_tgt};
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [3:0] max_su();
        return (m_asu[0] > m_asu[1]) ? m_asu[0] : m_asu[1];
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            m_srd[k] = 8'h59; m_swr[k] = 8'h59; m_ssu[k] = 4'h3;
            m_ard[k] = 8'h59; m_awr[k] = 8'h59; m_asu[k] = 4'h3;
        end
        m_tgt = 0; m_ctl = 0; m_cfg = 0;
    endtask

    task automatic acc(input logic [2:0] a, input logic rd, input logic wr,
                       input logic wide, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wide = wide; bus_wdata = d;
        #1;
        q = bus_rdata; trd = tf_rd; twr = tf_wr;
        @(posedge clk);
        #1;
        bus_rd = 0; bus_wr = 0;
    endtask

    // configuration write with model update
    task automatic cwr(input logic [2:0] a, input logic [7:0] d);
        acc(a, 1'b0, 1'b1, 1'b0, d);
        if (m_cfg) begin
            case (a)
                3'd0: m_srd[m_tgt] = d;
                3'd1: m_swr[m_tgt] = d;
                3'd2: if (d == 8'h83) m_cfg = 0;
                3'd3: begin
                    m_ctl = d;
                    if (d == 8'h85) begin
                        for (int k = 0; k < 2; k++) begin
                            m_ard[k] = m_srd[k]; m_awr[k] = m_swr[k]; m_asu[k] = m_ssu[k];
                        end
                    end
                end
                3'd6: begin m_tgt = d[0]; m_ssu[d[0]] = d[7:4]; end
                default: ;
            endcase
        end
    endtask

    task automatic crd(input string tag, input logic [2:0] a);
        logic [15:0] e;
        e = exp_read(a);
        acc(a, 1'b1, 1'b0, 1'b1, 8'h00);
        chk(tag, q, e);
    endtask

    task automatic unlock();
        acc(3'd1, 1'b1, 1'b0, 1'b1, 8'h00);
        acc(3'd1, 1'b1, 1'b0, 1'b1, 8'h00);
        acc(3'd2, 1'b0, 1'b1, 1'b0, 8'h03);
        m_cfg = 1;
    endtask

    task automatic check_outs(input string tag);
        @(negedge clk);
        chk({tag, " R8 rd_timing"}, {8'h0, rd_timing}, {8'h0, m_ard[dev_sel]});
        chk({tag, " R8 wr_timing"}, {8'h0, wr_timing}, {8'h0, m_awr[dev_sel]});
        chk({tag, " R8 addr_setup"}, {12'h0, addr_setup}, {12'h0, max_su()});
        chk({tag, " cfg_mode"}, {15'h0, cfg_mode}, {15'h0, m_cfg});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10 reset state
        check_outs("R10 reset");
        dev_sel = 1; check_outs("R10 reset dev1");

        // R4 taskfile forwarding while locked
        acc(3'd4, 1'b1, 1'b0, 1'b1, 8'h00);
        chk("R4 locked rdata", q, 16'hA5C3);
        chk("R4 locked tf_rd", {15'h0, trd}, 16'h1);
        acc(3'd4, 1'b0, 1'b1, 1'b0, 8'h12);
        chk("R4 locked tf_wr", {15'h0, twr}, 16'h1);

        // R1 unlock
        unlock();
        check_outs("R1 unlock");
        acc(3'd0, 1'b0, 1'b1, 1'b0, 8'h00);
        chk("R4 unlocked tf_wr", {15'h0, twr}, 16'h0);
        m_srd[m_tgt] = 8'h00;
        crd("R10 stg rd default?", 3'd1);
        crd("R5 offset0", 3'd0);
        acc(3'd0, 1'b1, 1'b0, 1'b1, 8'h00);
        chk("R4 unlocked tf_rd", {15'h0, trd}, 16'h0);
        crd("R10 misc default", 3'd6);
        crd("R10 ctl default", 3'd3);
        // R9 strap
        clk25_strap = 1; crd("R9 strap 25MHz", 3'd5);
        clk25_strap = 0; crd("R9 strap 33MHz", 3'd5);
        // R5 unused offsets
        cwr(3'd4, 8'hEE); crd("R5 offset4", 3'd4);
        cwr(3'd7, 8'hEE); crd("R5 offset7", 3'd7);
        // R3 non-close value at offset 2
        cwr(3'd2, 8'h03); check_outs("R3 keep unlocked");

        // R6 program set 1 then set 0
        cwr(3'd6, 8'h21); cwr(3'd0, 8'h46); cwr(3'd1, 8'h32);
        crd("R6 misc set1", 3'd6); crd("R6 rd set1", 3'd0);
        cwr(3'd6, 8'h10); cwr(3'd0, 8'h20); cwr(3'd1, 8'h30);
        crd("R6 misc set0", 3'd6);
        // R7 non-commit control value
        cwr(3'd3, 8'h84); crd("R7 ctl store", 3'd3);
        dev_sel = 0; check_outs("R7 no commit");
        cwr(3'd3, 8'h85);
        dev_sel = 0; check_outs("R7 commit dev0");
        dev_sel = 1; check_outs("R7 commit dev1");

        // R3 relock, R11 retention
        cwr(3'd2, 8'h83); check_outs("R3 relock");
        acc(3'd0, 1'b1, 1'b0, 1'b1, 8'h00);
        chk("R3 R4 relocked rdata", q, 16'hA5C3);
        unlock();
        crd("R11 misc kept", 3'd6); crd("R11 rd kept", 3'd0); crd("R11 wr kept", 3'd1);
        cwr(3'd6, 8'h01); crd("R11 set1 rd kept", 3'd0);
        check_outs("R11 active kept");
        cwr(3'd2, 8'h83);

        // R2 directed breaks
        for (int b = 0; b < 4; b++) begin
            acc(3'd1, 1'b1, 1'b0, 1'b1, 8'h00);
            acc(3'd1, 1'b1, 1'b0, 1'b1, 8'h00);
            case (b)
                0: acc(3'd1, 1'b1, 1'b0, 1'b0, 8'h00);
                1: acc(3'd0, 1'b1, 1'b0, 1'b1, 8'h00);
                2: acc(3'd2, 1'b0, 1'b1, 1'b0, 8'h04);
                default: acc(3'd1, 1'b0, 1'b1, 1'b0, 8'h00);
            endcase
            acc(3'd2, 1'b0, 1'b1, 1'b0, 8'h03);
            check_outs("R2 break");
        end
        // R2 break after a single read
        acc(3'd1, 1'b1, 1'b0, 1'b1, 8'h00);
        acc(3'd3, 1'b0, 1'b1, 1'b0, 8'h00);
        acc(3'd1, 1'b1, 1'b0, 1'b1, 8'h00);
        acc(3'd2, 1'b0, 1'b1, 1'b0, 8'h03);
        check_outs("R2 single break");
        // R1 three reads still unlock
        acc(3'd1, 1'b1, 1'b0, 1'b1, 8'h00);
        unlock();
        check_outs("R1 triple read");

        // random mix, R5 R6 R7 R8 R3
        for (int it = 0; it < 300; it++) begin
            int op;
            op = $urandom % 10;
            dev_sel = $urandom % 2;
            if (m_cfg) begin
                if (op < 5) cwr(3'($urandom % 8), 8'($urandom));
                else if (op < 8) crd("R5 random read", 3'($urandom % 8));
                else if (op == 8) cwr(3'd3, 8'h85);
                else cwr(3'd6, 8'($urandom));
            end else begin
                if (op < 6) unlock();
                else begin
                    acc(3'd5, 1'b1, 1'b0, 1'b1, 8'h00);
                    chk("R4 random locked read", q, tf_rdata);
                end
            end
            check_outs("R8 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule